// File: doc/BRIEF.md
# Five-Level Flying-Capacitor Switching State Selector

This block drives one phase leg of a five-level flying-capacitor inverter. Each update asks for an output level from -2 to +2 and gives the sign of the phase current. The block then picks a pattern for the four upper switches and drives the four lower switches as their complements. Between any switch-off and the matching switch-on of a pair, it inserts a programmable blanking interval.

Levels -1, 0 and +1 can each be made with several upper-switch patterns. Each pattern charges or discharges the flying capacitors in its own way. The block does not measure any capacitor voltage. Instead, each redundant level keeps its own rotation pointer, which moves on every time that level is entered. Over a full rotation every pattern of the level is used once, so the charge each capacitor gains is cancelled by the charge it loses. The pointer moves forward while the current flows out of the leg and backward while it flows in, which walks the same patterns in mirror order.

The modulator sits upstream and issues one level request at a time. The block moves at most one level per accepted update. A request that is still further away is approached over later updates.

Top module: `fc5_state_sel`

## Requirements
- R1: For each pair i, `gate_hi[i]` and `gate_lo[i]` are never both 1. While `busy` is 0, exactly one of them is 1.
- R2: While `busy` is 0, the number of ones in `gate_hi` equals `level_out + 2`.
- R3: Level +2 drives `gate_hi = 4'b1111`. Level -2 drives `gate_hi = 4'b0000`.
- R4: Switch code bit i stands for upper switch i+1. The patterns of level L are the codes with L+2 ones, listed in ascending numeric order and indexed from 0. On entry to a level, the pattern at that level's pointer is used. With `cur_pos = 1`, the pointer then steps forward, wrapping from the last pattern to 0.
- R5: With `cur_pos = 0`, the pointer steps backward after use, wrapping from 0 to the last pattern.
- R6: Each redundant level has its own pointer. A pointer moves only when its own level is newly entered. A request equal to the present level changes nothing.
- R7: An accepted change turns off both gates of every pair whose upper switch changes. They stay off for `dead_time` clocks after the accepting edge, and then the new state appears. Pairs that do not change are left alone. With `dead_time = 0`, the new state appears right after the accepting edge.
- R8: While reset is asserted, all gates are off, `busy` is 1 and `level_out` is -2, and all pointers are cleared. The lower gates turn on `dead_time` clocks after the first edge after reset is released.
- R9: A request is taken only on an edge where `busy` is 0. A request held only through busy cycles has no effect.
- R10: `level_req` (signed 3 bits) is clamped to -2..+2. Each accepted update moves `level_out` by exactly one step toward the clamped request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Level request present |
| level_req | input | 3 | Requested level, signed |
| cur_pos | input | 1 | 1 when phase current flows out of the leg |
| dead_time | input | 8 | Blanking length in clocks, 0 to 255 |
| gate_hi | output | 4 | Upper switch gates, bit i is switch i+1 |
| gate_lo | output | 4 | Lower complementary switch gates |
| busy | output | 1 | Start-up or blanking in progress |
| level_out | output | 3 | Level being applied, signed |

## Verification
An accepted request changes `level_out` and `busy`, and clears the gates of the changing pairs, on the accepting edge itself. The final gate pattern appears on the edge `dead_time` clocks later, or on the accepting edge when `dead_time` is 0. The bench therefore samples on the falling edge after the accepting edge and again after the last blanking edge. For blanking of two or more clocks, it also samples once just before the last blanking edge to confirm the gates are still off. After reset it counts the same number of edges from the first edge following release. A one-cycle request pulse is placed on the first blanking edge, and the level and gates are checked once blanking ends to confirm the pulse was ignored.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        PH_INIT  = 2'd0,
        PH_IDLE  = 2'd1,
        PH_BLANK = 2'd2
    } phase_e;

    // number of ways to choose k of n switches
    function automatic int choose(int n, int k);
        int r;
        r = 1;
        for (int j = 1; j <= k; j++) begin
            r = r * (n - k + j) / j;
        end
        return r;
    endfunction

endpackage

// File: rtl/fc_rotator.sv
module fc_rotator
    import fc_pkg::*;
#(
    parameter int N_CELL = 4,
    parameter int CNT_W  = $clog2(N_CELL + 1),
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] sel,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] idx_q [N_CELL+1];
    logic [IDX_W-1:0] idx_d [N_CELL+1];

    for (genvar k = 0; k <= N_CELL; k++) begin : g_lvl
        localparam int SZ = choose(N_CELL, k);

        always_comb begin
            idx_d[k] = idx_q[k];
            if (adv && (int'(sel) == k)) begin
                if (dir_up) begin
                    idx_d[k] = (int'(idx_q[k]) == SZ - 1) ? '0 : idx_q[k] + 1'b1;
                end else begin
                    idx_d[k] = (idx_q[k] == '0) ? IDX_W'(SZ - 1) : idx_q[k] - 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q[k] <= '0;
            end else begin
                idx_q[k] <= idx_d[k];
            end
        end
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k <= N_CELL; k++) begin
            if (int'(sel) == k) begin
                idx = idx_q[k];
            end
        end
    end

endmodule

// File: rtl/fc_pattern.sv
module fc_pattern #(
    parameter int N_CELL = 4,
    parameter int CNT_W  = $clog2(N_CELL + 1),
    parameter int IDX_W  = 3
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [IDX_W-1:0]  idx,
    output logic [N_CELL-1:0] pat
);

    localparam int NCODE = 1 << N_CELL;

    // pick the idx-th code (ascending) holding cnt ones
    always_comb begin
        int seen;
        seen = 0;
        pat  = '0;
        for (int v = 0; v < NCODE; v++) begin
            if ($countones(N_CELL'(v)) == int'(cnt)) begin
                if (seen == int'(idx)) begin
                    pat = N_CELL'(v);
                end
                seen = seen + 1;
            end
        end
    end

endmodule

// File: rtl/fc5_state_sel.sv
module fc5_state_sel
    import fc_pkg::*;
#(
    parameter int N_CELL = 4,
    parameter int DT_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic signed [2:0]       level_req,
    input  logic                    cur_pos,
    input  logic [DT_W-1:0]         dead_time,
    output logic [N_CELL-1:0]       gate_hi,
    output logic [N_CELL-1:0]       gate_lo,
    output logic                    busy,
    output logic signed [2:0]       level_out
);

    localparam int HALF  = N_CELL / 2;
    localparam int CNT_W = $clog2(N_CELL + 1);
    localparam int IDX_W = $clog2(choose(N_CELL, HALF) + 1);

    typedef struct packed {
        phase_e              ph;
        logic [N_CELL-1:0]   sw;
        logic [N_CELL-1:0]   blank;
        logic [DT_W-1:0]     cnt;
        logic [DT_W-1:0]     dt;
        logic signed [2:0]   lvl;
    } st_t;

    st_t st_q, st_d;

    logic               adv;
    logic [CNT_W-1:0]   tgt_cnt;
    logic [IDX_W-1:0]   rot_idx;
    logic [N_CELL-1:0]  new_pat;
    int                 req_c;
    int                 tgt;
    logic [DT_W-1:0]    dt_lat;

    fc_rotator #(.N_CELL(N_CELL), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rot (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .dir_up (cur_pos),
        .sel    (tgt_cnt),
        .idx    (rot_idx)
    );

    fc_pattern #(.N_CELL(N_CELL), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_pat (
        .cnt (tgt_cnt),
        .idx (rot_idx),
        .pat (new_pat)
    );

    // clamp request, then move one step
    always_comb begin
        req_c = int'(level_req);
        if (req_c > HALF)  req_c = HALF;
        if (req_c < -HALF) req_c = -HALF;
        if (req_c > int'(st_q.lvl)) begin
            tgt = int'(st_q.lvl) + 1;
        end else if (req_c < int'(st_q.lvl)) begin
            tgt = int'(st_q.lvl) - 1;
        end else begin
            tgt = int'(st_q.lvl);
        end
        tgt_cnt = CNT_W'(tgt + HALF);
    end

    always_comb begin
        st_d = st_q;
        adv  = 1'b0;
        case (st_q.ph)
            PH_INIT: begin
                st_d.dt  = dead_time;
                st_d.cnt = dead_time;
                if (dead_time == '0) begin
                    st_d.ph    = PH_IDLE;
                    st_d.blank = '0;
                end else begin
                    st_d.ph = PH_BLANK;
                end
            end
            PH_BLANK: begin
                if (st_q.cnt <= DT_W'(1)) begin
                    st_d.ph    = PH_IDLE;
                    st_d.blank = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_IDLE: begin
                if (req_valid && (tgt != int'(st_q.lvl))) begin
                    adv      = 1'b1;
                    st_d.sw  = new_pat;
                    st_d.lvl = 3'(tgt);
                    st_d.dt  = dead_time;
                    st_d.cnt = dead_time;
                    if (dead_time == '0) begin
                        st_d.blank = '0;
                    end else begin
                        st_d.blank = new_pat ^ st_q.sw;
                        st_d.ph    = PH_BLANK;
                    end
                end
            end
            default: begin
                st_d.ph = PH_INIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph    <= PH_INIT;
            st_q.sw    <= '0;
            st_q.blank <= '1;
            st_q.cnt   <= '0;
            st_q.dt    <= '0;
            st_q.lvl   <= 3'(-HALF);
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_hi   = st_q.sw & ~st_q.blank;
    assign gate_lo   = ~st_q.sw & ~st_q.blank;
    assign busy      = (st_q.ph != PH_IDLE);
    assign level_out = st_q.lvl;
    assign dt_lat    = st_q.dt;

endmodule

// File: rtl/fc_sel_checker.sv
module fc_sel_checker #(
    parameter int N_CELL = 4,
    parameter int DT_W   = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CELL-1:0]    gate_hi,
    input logic [N_CELL-1:0]    gate_lo,
    input logic                 busy,
    input logic signed [2:0]    level_out,
    input logic [DT_W-1:0]      dt_lat
);

    localparam int HALF = N_CELL / 2;

    // R2: steady pattern matches level
    p_level_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ($countones(gate_hi) == int'(level_out) + HALF));

    // R9: nothing accepted while busy
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (level_out == $past(level_out)));

    // R10: single step per update
    p_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (level_out != $past(level_out)) |->
        ((int'(level_out) - int'($past(level_out)) == 1) ||
         (int'(level_out) - int'($past(level_out)) == -1)));

    // R10: level stays in range
    p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level_out) <= HALF) && (int'(level_out) >= -HALF));

    for (genvar i = 0; i < N_CELL; i++) begin : g_pair
        // R7: no direct hand-over when blanking is set
        p_dead_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_lo[i]) && (dt_lat != '0)) |-> !$past(gate_hi[i]));
        p_dead_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_hi[i]) && (dt_lat != '0)) |-> !$past(gate_lo[i]));
        // R1: steady state drives exactly one device
        p_one_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |-> (gate_hi[i] ^ gate_lo[i]));
    end

endmodule

bind fc5_state_sel fc_sel_checker #(.N_CELL(N_CELL), .DT_W(DT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .busy      (busy),
    .level_out (level_out),
    .dt_lat    (dt_lat)
);

// File: tb/test_fc5_state_sel.sv
module test_fc5_state_sel;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic signed [2:0] level_req = '0;
    logic              cur_pos = 1'b1;
    logic [7:0]        dead_time = 8'd3;
    logic [3:0]        gate_hi;
    logic [3:0]        gate_lo;
    logic              busy;
    logic signed [2:0] level_out;

    int n_chk = 0;
    int n_bad = 0;
    int m_lvl;
    logic [3:0] m_sw;
    int rot [5];
    logic [15:0] lfsr = 16'hACE1;

    fc5_state_sel i_fc5_state_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .level_req (level_req),
        .cur_pos   (cur_pos),
        .dead_time (dead_time),
        .gate_hi   (gate_hi),
        .gate_lo   (gate_lo),
        .busy      (busy),
        .level_out (level_out)
    );

    always #4 clk = ~clk;

    initial begin
        #1600000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    function automatic int ways(int k);
        int r = 0;
        for (int v = 0; v < 16; v++) if ($countones(4'(v)) == k) r++;
        return r;
    endfunction

    function automatic logic [3:0] nth(int k, int i);
        int s = 0;
        logic [3:0] p = '0;
        for (int v = 0; v < 16; v++) begin
            if ($countones(4'(v)) == k) begin
                if (s == i) p = 4'(v);
                s++;
            end
        end
        return p;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(int dt);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        dead_time = 8'(dt);
        @(negedge clk);
        chk(gate_hi == 4'h0, "R8 hi in reset", gate_hi, 0);
        chk(gate_lo == 4'h0, "R8 lo in reset", gate_lo, 0);
        chk(busy == 1'b1, "R8 busy in reset", busy, 1);
        chk(int'(level_out) == -2, "R8 level in reset", level_out, -2);
        rst_n = 1'b1;
        m_lvl = -2;
        m_sw = 4'h0;
        for (int k = 0; k < 5; k++) rot[k] = 0;
        for (int j = 0; j <= dt; j++) begin
            @(negedge clk);
            if (j < dt) chk(gate_lo == 4'h0, "R8 lo blanked", gate_lo, 0);
        end
        chk(gate_lo == 4'hF, "R8 lo on", gate_lo, 15);
        chk(gate_hi == 4'h0, "R3 R8 hi off", gate_hi, 0);
        chk(busy == 1'b0, "R8 idle", busy, 0);
    endtask

    task automatic step_req(int req, bit cp, int dt);
        int rc, tg, k;
        logic [3:0] pat, chg;
        while (busy) @(negedge clk);
        level_req = 3'(req);
        cur_pos = cp;
        req_valid = 1'b1;
        rc = (req > 2) ? 2 : ((req < -2) ? -2 : req);
        tg = (rc > m_lvl) ? m_lvl + 1 : ((rc < m_lvl) ? m_lvl - 1 : m_lvl);
        if (tg == m_lvl) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(gate_hi == m_sw, "R6 same level hi", gate_hi, m_sw);
            chk(busy == 1'b0, "R6 same level busy", busy, 0);
            return;
        end
        k = tg + 2;
        pat = nth(k, rot[k]);
        if (cp) rot[k] = (rot[k] + 1) % ways(k);
        else    rot[k] = (rot[k] + ways(k) - 1) % ways(k);
        chg = pat ^ m_sw;
        @(negedge clk);
        chk(int'(level_out) == tg, "R10 step", level_out, tg);
        if (dt == 0) begin
            req_valid = 1'b0;
            chk(gate_hi == pat, "R4 R5 R7 hi no blank", gate_hi, pat);
            chk(gate_lo == ~pat, "R1 lo no blank", gate_lo, ~pat);
        end else begin
            chk(gate_hi == (pat & ~chg), "R7 hi blank", gate_hi, pat & ~chg);
            chk(gate_lo == (~pat & ~chg), "R7 lo blank", gate_lo, ~pat & ~chg);
            chk(busy == 1'b1, "R9 busy", busy, 1);
            level_req = 3'(-tg * 2);
            for (int j = 1; j <= dt; j++) begin
                @(negedge clk);
                if (j == 1) req_valid = 1'b0;
                if (j == dt - 1)
                    chk(gate_hi == (pat & ~chg), "R7 still blank", gate_hi, pat & ~chg);
            end
            chk(int'(level_out) == tg, "R9 pulse ignored", level_out, tg);
            chk(gate_hi == pat, "R4 R5 R6 hi", gate_hi, pat);
            chk(gate_lo == ~pat, "R1 lo", gate_lo, ~pat);
        end
        chk(busy == 1'b0, "R7 done", busy, 0);
        if (tg == 2)  chk(gate_hi == 4'hF, "R3 top", gate_hi, 15);
        if (tg == -2) chk(gate_hi == 4'h0, "R3 bottom", gate_hi, 0);
        m_lvl = tg;
        m_sw = pat;
    endtask

    initial begin
        int dts [4] = '{0, 1, 2, 5};
        for (int d = 0; d < 4; d++) begin
            do_reset(dts[d]);
            for (int c = 0; c < 2; c++) begin
                for (int rep = 0; rep < 8; rep++) begin
                    for (int s = 0; s < 4; s++) step_req(3, c == 0, dts[d]);
                    for (int s = 0; s < 4; s++) step_req(-4, c == 0, dts[d]);
                    step_req(-1, c == 0, dts[d]);
                    step_req(0, c == 0, dts[d]);
                    step_req(-1, c == 0, dts[d]);
                    step_req(-1, c == 0, dts[d]);
                end
            end
            for (int r = 0; r < 150; r++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step_req(int'(lfsr[2:0]) - 4, lfsr[7], dts[d]);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule